// File: doc/BRIEF.md
# Serial Receive Queue with Trigger and Character Timeout

This block sits behind a serial deserializer and holds received bytes until the host reads them. It works in one of two modes. In queued mode it keeps up to 16 bytes in arrival order, raises a trigger flag once a chosen fill level is reached, and flags a character timeout when data waits unread for too long. In direct mode it keeps a single holding byte. It also tracks data-ready, break and overrun status.

The host reaches the block through a control write, a data read strobe and a line-status read strobe. The control write selects the mode and the trigger level, and it can flush the receive queue and the transmit side. The data read strobe pops the oldest byte. The line-status read strobe clears the break and overrun flags.

The deserializer delivers either a byte or a break event. The character time is an input counted in clock cycles, and the timeout window is four times that value.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty and count, data_ready, brk, overrun, timeout_pend, trig_hit, tx_flush and ctl_q are all 0, so the block starts in direct mode.
- R2: The trigger field ctl_q[7:6] selects a level of 1, 4, 8 or 14 bytes for codes 0, 1, 2 and 3. In queued mode trig_hit is count >= level. In direct mode trig_hit equals data_ready.
- R3: In a control write, bit 0 selects queued mode, bit 1 flushes the receive side and bit 2 flushes the transmit side. tx_flush pulses for the one cycle after a transmit flush. ctl_q keeps only the written bits under mask 0xC9.
- R4: A control write that changes bit 0 performs both flushes, even when bits 1 and 2 are 0.
- R5: A receive flush empties the queue and clears data_ready, brk and timeout_pend. It also stops the timeout. It leaves overrun and the direct-mode holding byte unchanged.
- R6: In queued mode, a byte that arrives while 16 bytes are held is dropped and sets overrun. The stored bytes and the count are kept.
- R7: In direct mode, a new byte replaces the holding byte and sets data_ready. It also sets overrun if data_ready was already 1. count stays 0 in direct mode.
- R8: A break event is stored as a byte of value 0x00 and sets brk and data_ready. A break takes priority over rx_valid in the same cycle.
- R9: In queued mode, the timeout is restarted by every arriving byte and by every read that leaves data in the queue. It expires 4*char_cycles cycles after the last restart (at least 1 cycle). timeout_pend then rises only if the queue is not empty. Any read in queued mode clears timeout_pend.
- R10: rd_data shows the oldest byte in queued mode, or 0 if the queue is empty, and shows the holding byte in direct mode. A read that leaves the queue empty, and any read in direct mode, clears data_ready and brk.
- R11: lsr_rd clears brk and overrun. A new event in the same cycle sets them again.
- R12: In a single cycle the read is applied before the arriving byte, so a full queue that is read accepts the new byte. A receive flush discards any read and arriving byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| char_cycles | input | 16 | One character time, in clock cycles |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write value |
| ctl_q | output | 8 | Retained control bits |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break event strobe |
| rd_en | input | 1 | Data read strobe (pop) |
| rd_data | output | 8 | Oldest byte or holding byte |
| lsr_rd | input | 1 | Line-status read strobe |
| count | output | 5 | Bytes held in the queue |
| data_ready | output | 1 | Data available |
| brk | output | 1 | Break received |
| overrun | output | 1 | A byte was lost |
| trig_hit | output | 1 | Trigger level reached |
| timeout_pend | output | 1 | Character timeout pending |
| tx_flush | output | 1 | Transmit-side flush pulse |

## Verification
The assertions check several invariants on every cycle. In queued mode data_ready always agrees with a non-zero count, and a pending timeout always implies stored data. The count never exceeds the depth and stays 0 in direct mode. A write arriving at a full queue keeps the count and raises overrun, and a mode change leaves the queue empty with a transmit flush pulse. Byte ordering, trigger thresholds, break bytes, the exact expiry cycle of the timeout and same-cycle priorities are shown only by the bench. The bench compares every output against a reference model on each cycle, during both directed and random traffic.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1),
  localparam int TW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] char_cycles,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_q,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          lsr_rd,
  output logic [NW-1:0] count,
  output logic          data_ready,
  output logic          brk,
  output logic          overrun,
  output logic          trig_hit,
  output logic          timeout_pend,
  output logic          tx_flush
);

  logic [7:0]    fcr;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [NW-1:0] cnt, lvl;
  logic          dr, bk, ov, pend, run, txf;
  logic          dr_n, bk_n, ov_n;
  logic [TW-1:0] tmr;
  logic [DW-1:0] hold, hold_n;

  wire fen      = fcr[0];
  wire en_flip  = ctl_we & (ctl_wdata[0] ^ fen);
  wire rst_rx   = (ctl_we & ctl_wdata[1]) | en_flip;
  wire rst_tx   = (ctl_we & ctl_wdata[2]) | en_flip;
  wire do_rd    = rd_en & ~rst_rx;
  wire do_push  = (rx_valid | rx_break) & ~rst_rx;
  wire [DW-1:0] pbyte = rx_break ? '0 : rx_data;
  wire pop      = do_rd & fen & (cnt != '0);
  wire [NW-1:0] cnt_mid = cnt - NW'(pop);
  wire accept   = do_push & fen & (cnt_mid != NW'(DEPTH));
  wire [NW-1:0] cnt_nx = cnt_mid + NW'(accept);
  wire restart  = fen & (do_push | (do_rd & (cnt_mid != '0)));
  wire expire   = run & ~restart & (tmr <= TW'(1));
  wire [TW-1:0] tmo_load = {char_cycles, 2'b00};

  always_comb begin
    case (fcr[7:6])
      2'd0:    lvl = NW'(1);
      2'd1:    lvl = NW'(4);
      2'd2:    lvl = NW'(8);
      default: lvl = NW'(14);
    endcase
  end

  always_comb begin
    dr_n = dr; bk_n = bk; ov_n = ov; hold_n = hold;
    if (lsr_rd) begin bk_n = 1'b0; ov_n = 1'b0; end
    if (do_rd && (!fen || cnt_mid == '0)) begin dr_n = 1'b0; bk_n = 1'b0; end
    if (do_push) begin
      if (fen ? !accept : dr_n) ov_n = 1'b1;
      if (!fen) hold_n = pbyte;
      dr_n = 1'b1;
      if (rx_break) bk_n = 1'b1;
    end
    if (rst_rx) begin dr_n = 1'b0; bk_n = 1'b0; end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= pbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr <= '0; rp <= '0; wp <= '0; cnt <= '0;
      dr <= 1'b0; bk <= 1'b0; ov <= 1'b0; hold <= '0;
      pend <= 1'b0; run <= 1'b0; tmr <= '0; txf <= 1'b0;
    end else begin
      txf <= rst_tx;
      dr <= dr_n; bk <= bk_n; ov <= ov_n; hold <= hold_n;
      if (ctl_we) fcr <= ctl_wdata & 8'hC9;
      if (rst_rx) begin
        rp <= '0; wp <= '0; cnt <= '0;
        pend <= 1'b0; run <= 1'b0;
      end else begin
        cnt <= cnt_nx;
        if (pop)    rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        if (accept) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (fen && do_rd) pend <= 1'b0;
        if (restart) begin
          tmr <= tmo_load; run <= 1'b1;
        end else if (expire) begin
          run <= 1'b0;
          if (cnt_nx != '0) pend <= 1'b1;
        end else if (run) begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end

  assign ctl_q        = fcr;
  assign rd_data      = fen ? ((cnt != '0) ? mem[rp] : '0) : hold;
  assign count        = cnt;
  assign data_ready   = dr;
  assign brk          = bk;
  assign overrun      = ov;
  assign trig_hit     = fen ? (cnt >= lvl) : dr;
  assign timeout_pend = pend;
  assign tx_flush     = txf;

endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int NW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rd_en,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic [7:0]    ctl_q,
  input logic [NW-1:0] count,
  input logic          data_ready,
  input logic          overrun,
  input logic          trig_hit,
  input logic          timeout_pend,
  input logic          tx_flush
);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));

  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == NW'(DEPTH) && rx_valid && !rd_en && !ctl_we) |=> (overrun && count == NW'(DEPTH)));

  a_r4_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (ctl_wdata[0] != ctl_q[0])) |=> (tx_flush && count == '0 && !data_ready));

  a_r10_ready_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |-> (data_ready == (count != '0)));

  a_r9_pend_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pend |-> (count != '0));

  a_r2_trig_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && trig_hit) |-> (count != '0));

  a_r7_direct_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |-> (count == '0));

endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .NW(NW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_en(rd_en),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .count(count),
  .data_ready(data_ready), .overrun(overrun), .trig_hit(trig_hit),
  .timeout_pend(timeout_pend), .tx_flush(tx_flush)
);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] char_cycles = 16'd2;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_q;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_break = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        lsr_rd = 1'b0;
  logic [4:0]  count;
  logic        data_ready, brk, overrun, trig_hit, timeout_pend, tx_flush;

  always #5ns clk = ~clk;

  uart_rx_queue dut_i (
    .clk(clk), .rst_n(rst_n), .char_cycles(char_cycles),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .rd_en(rd_en), .rd_data(rd_data), .lsr_rd(lsr_rd), .count(count),
    .data_ready(data_ready), .brk(brk), .overrun(overrun),
    .trig_hit(trig_hit), .timeout_pend(timeout_pend), .tx_flush(tx_flush)
  );

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  logic [7:0] m_buf [16];
  int         m_cnt, m_tc;
  logic [7:0] m_fcr, m_hold;
  bit         m_dr, m_bk, m_ov, m_pend, m_run, m_txf;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lvl_of(logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd();
    if (m_fcr[0]) return (m_cnt > 0) ? m_buf[0] : 8'h00;
    return m_hold;
  endfunction

  function automatic int exp_trig();
    if (m_fcr[0]) return (m_cnt >= lvl_of(m_fcr[7:6])) ? 1 : 0;
    return m_dr ? 1 : 0;
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_tc = 0; m_fcr = '0; m_hold = '0;
    m_dr = 0; m_bk = 0; m_ov = 0; m_pend = 0; m_run = 0; m_txf = 0;
  endtask

  task automatic m_step();
    bit fen, flip, rr, rt, drd, dpu, rs;
    logic [7:0] b;
    fen  = m_fcr[0];
    flip = ctl_we && (ctl_wdata[0] != m_fcr[0]);
    rr   = (ctl_we && ctl_wdata[1]) || flip;
    rt   = (ctl_we && ctl_wdata[2]) || flip;
    drd  = rd_en && !rr;
    dpu  = (rx_valid || rx_break) && !rr;
    b    = rx_break ? 8'h00 : rx_data;
    rs   = 0;
    if (lsr_rd) begin m_bk = 0; m_ov = 0; end
    if (fen) begin
      if (drd) begin
        if (m_cnt > 0) begin
          for (int i = 0; i < 15; i++) m_buf[i] = m_buf[i+1];
          m_cnt--;
        end
        if (m_cnt == 0) begin m_dr = 0; m_bk = 0; end else rs = 1;
        m_pend = 0;
      end
      if (dpu) begin
        if (m_cnt < 16) begin m_buf[m_cnt] = b; m_cnt++; end else m_ov = 1;
        m_dr = 1;
        if (rx_break) m_bk = 1;
        rs = 1;
      end
    end else begin
      if (drd) begin m_dr = 0; m_bk = 0; end
      if (dpu) begin
        if (m_dr) m_ov = 1;
        m_hold = b; m_dr = 1;
        if (rx_break) m_bk = 1;
      end
    end
    if (rs) begin m_tc = 4 * int'(char_cycles); m_run = 1; end
    else if (m_run) begin
      if (m_tc <= 1) begin m_run = 0; if (m_cnt != 0) m_pend = 1; end
      else m_tc--;
    end
    if (rr) begin m_cnt = 0; m_dr = 0; m_bk = 0; m_pend = 0; m_run = 0; end
    if (ctl_we) m_fcr = ctl_wdata & 8'hC9;
    m_txf = rt;
  endtask

  task automatic cmp_all();
    chk("R10", "data_ready", int'(data_ready), int'(m_dr));
    chk("R8",  "brk", int'(brk), int'(m_bk));
    chk("R6",  "overrun", int'(overrun), int'(m_ov));
    chk("R6",  "count", int'(count), m_cnt);
    chk("R2",  "trig_hit", int'(trig_hit), exp_trig());
    chk("R9",  "timeout_pend", int'(timeout_pend), int'(m_pend));
    chk("R3",  "ctl_q", int'(ctl_q), int'(m_fcr));
    chk("R4",  "tx_flush", int'(tx_flush), int'(m_txf));
  endtask

  task automatic step(bit v, logic [7:0] d, bit bk, bit rd, bit ls, bit we, logic [7:0] w);
    bit flip;
    rx_valid = v; rx_data = d; rx_break = bk; rd_en = rd; lsr_rd = ls;
    ctl_we = we; ctl_wdata = w;
    #1;
    flip = we && (w[0] != m_fcr[0]);
    if (rd && !(we && (w[1] || flip)))
      chk("R10", "rd_data", int'(rd_data), int'(exp_rd()));
    m_step();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] first;
    process::self().srandom(32'h5EED_1234);
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "data_ready", int'(data_ready), 0);
    chk("R1", "ctl_q", int'(ctl_q), 0);
    chk("R1", "timeout_pend", int'(timeout_pend), 0);
    chk("R1", "trig_hit", int'(trig_hit), 0);
    cmp_all();

    // R7: direct mode overwrite and overrun
    step(1, 8'h11, 0, 0, 0, 0, 8'h00);
    step(1, 8'h22, 0, 0, 0, 0, 8'h00);
    chk("R7", "overrun after second byte", int'(overrun), 1);
    chk("R7", "count in direct mode", int'(count), 0);
    chk("R7", "holding byte", int'(rd_data), 8'h22);
    step(0, 8'h00, 0, 1, 0, 0, 8'h00);
    chk("R10", "direct read clears ready", int'(data_ready), 0);
    // R11: line-status read clears overrun
    step(0, 8'h00, 0, 0, 1, 0, 8'h00);
    chk("R11", "overrun cleared", int'(overrun), 0);

    // R4: enable queued mode with level code 1 -> implicit flushes
    step(0, 8'h00, 0, 0, 0, 1, 8'h41);
    chk("R4", "tx_flush on enable change", int'(tx_flush), 1);
    // R3: mask 0xC9, tx flush bit without mode change
    step(0, 8'h00, 0, 0, 0, 1, 8'hF7);
    chk("R3", "ctl_q masked", int'(ctl_q), 8'hC1);
    chk("R3", "tx_flush from bit 2", int'(tx_flush), 1);
    step(0, 8'h00, 0, 0, 0, 1, 8'h41);
    chk("R3", "tx_flush ends", int'(tx_flush), 0);

    // R6: fill 16 then overflow
    for (int i = 0; i < 17; i++) step(1, 8'(8'hA0 + i), 0, 0, 0, 0, 8'h00);
    chk("R6", "count at full", int'(count), 16);
    chk("R6", "overrun", int'(overrun), 1);
    chk("R2", "trigger at full", int'(trig_hit), 1);
    first = rd_data;
    chk("R6", "oldest kept", int'(first), 8'hA0);
    // R12: read and push in same cycle at full accepts
    step(1, 8'hEE, 0, 1, 1, 0, 8'h00);
    chk("R12", "count stays full", int'(count), 16);
    chk("R11", "overrun cleared w/o new drop", int'(overrun), 0);
    // R5 and R12: receive flush discards same-cycle read and byte
    step(1, 8'h55, 0, 1, 0, 1, 8'h43);
    chk("R5", "count after rx flush", int'(count), 0);
    chk("R12", "byte discarded by flush", int'(data_ready), 0);

    // R8: break stored as zero
    step(1, 8'h77, 1, 0, 0, 0, 8'h00);
    chk("R8", "brk set", int'(brk), 1);
    chk("R8", "break byte", int'(rd_data), 0);
    step(0, 8'h00, 0, 1, 0, 0, 8'h00);
    chk("R10", "empty read clears brk", int'(brk), 0);
    step(0, 8'h00, 0, 1, 0, 0, 8'h00); // empty read, rd_data checked as 0

    // R9: timeout after exactly 4*char_cycles
    char_cycles = 16'd3;
    step(1, 8'h31, 0, 0, 0, 0, 8'h00);
    idle(11);
    chk("R9", "not yet pending", int'(timeout_pend), 0);
    idle(1);
    chk("R9", "pending after window", int'(timeout_pend), 1);
    step(1, 8'h32, 0, 0, 0, 0, 8'h00);
    step(0, 8'h00, 0, 1, 0, 0, 8'h00);
    chk("R9", "read clears pending", int'(timeout_pend), 0);
    // R5: flush stops a running timer, overrun retained
    step(1, 8'h40, 0, 0, 0, 0, 8'h00);
    step(0, 8'h00, 0, 0, 0, 1, 8'h83);
    idle(14);
    chk("R5", "no timeout after flush", int'(timeout_pend), 0);
    // R2: level code 2 -> 8 bytes
    for (int i = 0; i < 7; i++) step(1, 8'(i), 0, 0, 0, 0, 8'h00);
    chk("R2", "below level 8", int'(trig_hit), 0);
    step(1, 8'h07, 0, 0, 0, 0, 8'h00);
    chk("R2", "at level 8", int'(trig_hit), 1);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit v, b, rd, ls, we;
      logic [7:0] d, w;
      if (($urandom % 50) == 0) char_cycles = 16'(1 + $urandom % 4);
      v  = ($urandom % 10) < 4;
      b  = ($urandom % 32) == 0;
      rd = ($urandom % 10) < 3;
      ls = ($urandom % 16) == 0;
      we = ($urandom % 64) == 0;
      d  = 8'($urandom);
      w  = 8'($urandom);
      if (($urandom % 4) != 0) w[0] = m_fcr[0];
      step(v, d, b, rd, ls, we, w);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule